// File: doc/BRIEF.md
# Binary-Field Montgomery Ladder Datapath

This block computes the projective main loop of the elliptic-curve scalar multiplication Q = kP over a binary field GF(2^M), with M = 163 by default. It uses the x-only Montgomery ladder in Lopez–Dahab coordinates. A caller supplies the affine x-coordinate of P, the curve constant b and a KW-bit scalar, then pulses a start strobe. The block returns two projective points, (X1 : Z1) = kP and (X2 : Z2) = (k+1)P. A later stage converts them to affine form with an inversion and recovers y. That conversion is not part of this block.

Three bit-serial field multipliers run in lockstep. Each ladder step uses them twice: once for a phase that forms the cross products and the doubling product, and once for a phase that forms the final products. The key bit decides which coordinate pair is added into and which pair is doubled. Squarers are combinational interleave-and-reduce networks. Additions are XORs. The block starts from the pair (point at infinity, P) and always walks every scalar bit from KW-1 down to 0. Leading zero bits leave that starting pair unchanged, so the run time does not depend on the scalar value.

Top module: `gf2m_ladder`

## Requirements
- R1: While reset is held, and after it is released, x1_o, z1_o, x2_o and z2_o are all zero and done_o is low until the first start is accepted.
- R2: A start accepted while idle captures xp_i, b_i and k_i. It sets the pair to X1=1, Z1=0, X2=xp, Z2=1 and processes scalar bits from index KW-1 down to 0. Leading zero bits leave the pair unchanged.
- R3: For a scalar bit of 1 the step writes Z1 = (X1·Z2 + X2·Z1)², X1 = xp·Z1new + (X1·Z2)(X2·Z1), Z2 = X2²·Z2² and X2 = X2⁴ + b·Z2⁴.
- R4: For a scalar bit of 0 the step writes Z2 = (X1·Z2 + X2·Z1)², X2 = xp·Z2new + (X1·Z2)(X2·Z1), Z1 = X1²·Z1² and X1 = X1⁴ + b·Z1⁴.
- R5: Addition is bitwise XOR. Products and squares are reduced modulo x^M + POLY, where bit i of POLY is the coefficient of x^i. The default POLY is bits 7, 6, 3 and 0, which gives x^163 + x^7 + x^6 + x^3 + 1.
- R6: Each multiplication takes exactly M shift cycles. A ladder step takes 2M+4 clock cycles. done_o is high in the cycle that follows the clock edge KW·(2M+4) edges after the edge that sampled start.
- R7: done_o is a single-cycle pulse. After it, all four outputs hold their values until the next accepted start.
- R8: A start pulse while a run is in progress has no effect. The run finishes at the same cycle with the results for the scalar captured originally.
- R9: k = 0 yields X1 = 1 and Z1 = 0 (the point at infinity). k = 1 yields X1 = xp, Z1 = 1, X2 = xp⁴ + b and Z2 = xp².
- R10: The three multipliers start and finish in the same cycles. A multiplier signals completion only inside a multiplication-wait phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, sampled only while idle |
| xp_i | input | M | Affine x-coordinate of the base point |
| b_i | input | M | Curve constant b |
| k_i | input | KW | Scalar, scanned from bit KW-1 down to bit 0 |
| x1_o | output | M | Projective X of kP |
| z1_o | output | M | Projective Z of kP |
| x2_o | output | M | Projective X of (k+1)P |
| z2_o | output | M | Projective Z of (k+1)P |
| done_o | output | 1 | One-cycle pulse when the last scalar bit has been processed |

## Verification
The hardest situation to reach from the ports is a start strobe that lands in the middle of a multiplication phase while it carries a different scalar. The bench raises start a few cycles into a run with the scalar input inverted. It then requires that the final coordinates match the model for the original scalar and that done_o appears exactly on the original cycle. The bit-0 swap path only shows up when the scalar mixes ones and zeros after its leading one. For that reason the small 7-bit field instance is driven with patterns such as alternating bits, all ones and a lone top bit. The 163-bit instance is driven with random scalars and points.

// File: rtl/ladder_pkg.sv
`timescale 1ns/1ps
package ladder_pkg;

   // Controller phases: each ladder step is GO/WAIT for phase one, then GO/WAIT for phase two
   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_P1GO   = 3'd1,
      ST_P1WAIT = 3'd2,
      ST_P2GO   = 3'd3,
      ST_P2WAIT = 3'd4
   } ladder_st_e;

   localparam int unsigned NUM_MULT = 3;

endpackage

// File: rtl/gf_sqr.sv
`timescale 1ns/1ps
// Combinational squarer in GF(2^M): spread the bits onto even positions, then fold
// everything at or above x^M back down with the reduction polynomial.
module gf_sqr #(
   parameter int          M    = 163,
   parameter logic [M-1:0] POLY = M'('hC9)
) (
   input  logic [M-1:0] a_i,
   output logic [M-1:0] y_o
);

   localparam int W2 = 2*M - 1;

   logic [W2-1:0] spread;

   always_comb begin
      spread = '0;
      for (int i = 0; i < M; i++) begin
         spread[2*i] = a_i[i];
      end
      for (int i = W2 - 1; i >= M; i--) begin
         if (spread[i]) begin
            spread[i-M +: M] = spread[i-M +: M] ^ POLY;
            spread[i]        = 1'b0;
         end
      end
      y_o = spread[M-1:0];
   end

endmodule

// File: rtl/gf_mul_serial.sv
`timescale 1ns/1ps
// Bit-serial GF(2^M) multiplier, most significant multiplier bit first, reduction
// interleaved with each shift. M cycles per product; done is a one-cycle pulse.
module gf_mul_serial #(
   parameter int           M    = 163,
   parameter logic [M-1:0] POLY = M'('hC9)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start_i,
   input  logic [M-1:0] a_i,
   input  logic [M-1:0] b_i,
   output logic         done_o,
   output logic [M-1:0] p_o
);

   localparam int CW = $clog2(M + 1);

   logic [M-1:0]  a_q, b_q, acc_q;
   logic [CW-1:0] cnt_q;
   logic          busy_q, done_q;
   logic [M-1:0]  acc_shift, acc_next;

   always_comb begin
      acc_shift = {acc_q[M-2:0], 1'b0} ^ (acc_q[M-1] ? POLY : '0);
      acc_next  = acc_shift ^ (a_q[M-1] ? b_q : '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_q    <= '0;
         b_q    <= '0;
         acc_q  <= '0;
         cnt_q  <= '0;
         busy_q <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (start_i && !busy_q) begin
            a_q    <= a_i;
            b_q    <= b_i;
            acc_q  <= '0;
            cnt_q  <= CW'(M);
            busy_q <= 1'b1;
         end else if (busy_q) begin
            acc_q <= acc_next;
            a_q   <= {a_q[M-2:0], 1'b0};
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CW'(1)) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
            end
         end
      end
   end

   assign done_o = done_q;
   assign p_o    = acc_q;

   // independent run-length counter for the latency check
   logic [CW-1:0] run_len_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   run_len_q <= '0;
      else if (start_i && !busy_q)  run_len_q <= '0;
      else if (busy_q)              run_len_q <= run_len_q + 1'b1;
   end

   // R6
   mul_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> (run_len_q == CW'(M)));

   // R6
   mul_done_follows_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> ($past(busy_q) && !busy_q));

endmodule

// File: rtl/gf2m_ladder.sv
`timescale 1ns/1ps
// Lopez-Dahab Montgomery ladder main loop over GF(2^M) with three lockstep multipliers.
module gf2m_ladder
   import ladder_pkg::*;
#(
   parameter int           M    = 163,
   parameter int           KW   = 163,
   parameter logic [M-1:0] POLY = M'('hC9)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic [M-1:0]  xp_i,
   input  logic [M-1:0]  b_i,
   input  logic [KW-1:0] k_i,
   output logic [M-1:0]  x1_o,
   output logic [M-1:0]  z1_o,
   output logic [M-1:0]  x2_o,
   output logic [M-1:0]  z2_o,
   output logic          done_o
);

   localparam int IW = $clog2(KW);

   // elaboration-time parameter checks
   if (M < 3) begin : g_bad_m
      $error("gf2m_ladder: M must be at least 3");
   end
   if (KW < 2) begin : g_bad_kw
      $error("gf2m_ladder: KW must be at least 2");
   end
   if (POLY[0] != 1'b1) begin : g_bad_poly
      $error("gf2m_ladder: reduction polynomial needs a constant term");
   end

   ladder_st_e    state_q;
   logic [IW-1:0] idx_q;
   logic [KW-1:0] k_q;
   logic [M-1:0]  xp_q, b_q;
   logic [M-1:0]  x1_q, z1_q, x2_q, z2_q;
   logic [M-1:0]  pa_q, pb_q, pc_q;
   logic          done_q;

   // ---------------- operand selection by key bit ----------------
   logic          kbit;
   logic [M-1:0]  xd, zd;
   logic [M-1:0]  xd2, zd2, xd4, zd4, sab;

   assign kbit = k_q[idx_q];
   assign xd   = kbit ? x2_q : x1_q;   // pair being doubled
   assign zd   = kbit ? z2_q : z1_q;

   gf_sqr #(.M(M), .POLY(POLY)) u_sq_xd  (.a_i(xd),          .y_o(xd2));
   gf_sqr #(.M(M), .POLY(POLY)) u_sq_zd  (.a_i(zd),          .y_o(zd2));
   gf_sqr #(.M(M), .POLY(POLY)) u_sq_xd4 (.a_i(xd2),         .y_o(xd4));
   gf_sqr #(.M(M), .POLY(POLY)) u_sq_zd4 (.a_i(zd2),         .y_o(zd4));
   gf_sqr #(.M(M), .POLY(POLY)) u_sq_sum (.a_i(pa_q ^ pb_q), .y_o(sab));

   // ---------------- three lockstep multipliers ----------------
   logic [M-1:0]          op_a [NUM_MULT];
   logic [M-1:0]          op_b [NUM_MULT];
   logic [M-1:0]          prod [NUM_MULT];
   logic [NUM_MULT-1:0]   mdone;
   logic                  mul_go;
   logic                  phase2;

   assign mul_go = (state_q == ST_P1GO) || (state_q == ST_P2GO);
   assign phase2 = (state_q == ST_P2GO);

   always_comb begin
      if (phase2) begin
         op_a[0] = xp_q;  op_b[0] = sab;     // xp * new Z of the added pair
         op_a[1] = pa_q;  op_b[1] = pb_q;    // cross-product product
         op_a[2] = b_q;   op_b[2] = zd4;     // b * Zd^4
      end else begin
         op_a[0] = x1_q;  op_b[0] = z2_q;
         op_a[1] = x2_q;  op_b[1] = z1_q;
         op_a[2] = xd2;   op_b[2] = zd2;     // Xd^2 * Zd^2
      end
   end

   for (genvar g = 0; g < NUM_MULT; g++) begin : g_mul
      gf_mul_serial #(.M(M), .POLY(POLY)) u_mul (
         .clk     (clk),
         .rst_n   (rst_n),
         .start_i (mul_go),
         .a_i     (op_a[g]),
         .b_i     (op_b[g]),
         .done_o  (mdone[g]),
         .p_o     (prod[g])
      );
   end

   logic [M-1:0] xa_new, xd_new;
   assign xa_new = prod[0] ^ prod[1];
   assign xd_new = xd4 ^ prod[2];

   // ---------------- controller ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         idx_q   <= '0;
         k_q     <= '0;
         xp_q    <= '0;
         b_q     <= '0;
         x1_q    <= '0;
         z1_q    <= '0;
         x2_q    <= '0;
         z2_q    <= '0;
         pa_q    <= '0;
         pb_q    <= '0;
         pc_q    <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  xp_q    <= xp_i;
                  b_q     <= b_i;
                  k_q     <= k_i;
                  x1_q    <= M'(1);
                  z1_q    <= '0;
                  x2_q    <= xp_i;
                  z2_q    <= M'(1);
                  idx_q   <= IW'(KW - 1);
                  state_q <= ST_P1GO;
               end
            end
            ST_P1GO:   state_q <= ST_P1WAIT;
            ST_P1WAIT: begin
               if (mdone[0]) begin
                  pa_q    <= prod[0];
                  pb_q    <= prod[1];
                  pc_q    <= prod[2];
                  state_q <= ST_P2GO;
               end
            end
            ST_P2GO:   state_q <= ST_P2WAIT;
            ST_P2WAIT: begin
               if (mdone[0]) begin
                  if (kbit) begin
                     x1_q <= xa_new;  z1_q <= sab;
                     x2_q <= xd_new;  z2_q <= pc_q;
                  end else begin
                     x2_q <= xa_new;  z2_q <= sab;
                     x1_q <= xd_new;  z1_q <= pc_q;
                  end
                  if (idx_q == '0) begin
                     done_q  <= 1'b1;
                     state_q <= ST_IDLE;
                  end else begin
                     idx_q   <= idx_q - 1'b1;
                     state_q <= ST_P1GO;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign x1_o   = x1_q;
   assign z1_o   = z1_q;
   assign x2_o   = x2_q;
   assign z2_o   = z2_q;
   assign done_o = done_q;

   // ---------------- assertions ----------------
   // R10
   mul_lockstep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mdone[0] |-> (mdone[1] && mdone[2]));

   // R10
   mul_done_in_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|mdone) |-> (state_q == ST_P1WAIT || state_q == ST_P2WAIT));

   // R7
   done_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);

   // R7
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE && !start_i) |=>
         ($stable(x1_q) && $stable(z1_q) && $stable(x2_q) && $stable(z2_q)));

   // R8
   busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_IDLE && start_i) |=> ($stable(k_q) && $stable(xp_q)));

   // R9
   zero_scalar_infinity_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_q && k_q == '0) |-> (z1_q == '0 && x1_q == M'(1)));

endmodule

// File: tb/test_gf2m_ladder.sv
`timescale 1ns/1ps
module test_gf2m_ladder;

   localparam int            MB = 163;
   localparam int            KB = 32;
   localparam logic [162:0]  PB = 163'hC9;
   localparam int            MS = 7;
   localparam int            KS = 6;
   localparam logic [6:0]    PS = 7'h03;   // x^7 + x + 1

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic          rst_n;
   logic          st_b, st_s;
   logic [162:0]  xp, bb;
   logic [31:0]   kk;
   logic          sel;

   logic [162:0]  b_x1, b_z1, b_x2, b_z2;
   logic          b_done;
   logic [6:0]    s_x1, s_z1, s_x2, s_z2;
   logic          s_done;

   gf2m_ladder #(.M(MB), .KW(KB), .POLY(PB)) i_gf2m_ladder (
      .clk(clk), .rst_n(rst_n), .start_i(st_b), .xp_i(xp), .b_i(bb), .k_i(kk),
      .x1_o(b_x1), .z1_o(b_z1), .x2_o(b_x2), .z2_o(b_z2), .done_o(b_done));

   gf2m_ladder #(.M(MS), .KW(KS), .POLY(PS)) i_gf2m_ladder_small (
      .clk(clk), .rst_n(rst_n), .start_i(st_s), .xp_i(xp[6:0]), .b_i(bb[6:0]),
      .k_i(kk[5:0]),
      .x1_o(s_x1), .z1_o(s_z1), .x2_o(s_x2), .z2_o(s_z2), .done_o(s_done));

   logic [162:0] rx1, rz1, rx2, rz2;
   logic         rdone;
   assign rx1   = sel ? b_x1 : {156'd0, s_x1};
   assign rz1   = sel ? b_z1 : {156'd0, s_z1};
   assign rx2   = sel ? b_x2 : {156'd0, s_x2};
   assign rz2   = sel ? b_z2 : {156'd0, s_z2};
   assign rdone = sel ? b_done : s_done;

   int n_chk  = 0;
   int n_fail = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [162:0] act, input logic [162:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // ---------------- behavioural field model ----------------
   function automatic logic [162:0] fmask(input int m);
      logic [162:0] r = '0;
      for (int i = 0; i < m; i++) r[i] = 1'b1;
      return r;
   endfunction

   function automatic logic [162:0] fmul(input logic [162:0] a, input logic [162:0] b,
                                          input int m, input logic [162:0] p);
      logic [162:0] acc = '0;
      logic         top;
      for (int i = m - 1; i >= 0; i--) begin
         top = acc[m-1];
         acc = (acc << 1) & fmask(m);
         if (top)  acc = acc ^ p;
         if (a[i]) acc = acc ^ b;
      end
      return acc;
   endfunction

   // ladder model: formulas applied directly, one key bit at a time
   task automatic model(input logic [162:0] x, input logic [162:0] b, input logic [31:0] k,
                        input int m, input int kw, input logic [162:0] p,
                        output logic [162:0] ox1, output logic [162:0] oz1,
                        output logic [162:0] ox2, output logic [162:0] oz2);
      logic [162:0] x1, z1, x2, z2, t1, t2, s, q;
      x1 = 163'd1; z1 = '0; x2 = x; z2 = 163'd1;
      for (int i = kw - 1; i >= 0; i--) begin
         t1 = fmul(x1, z2, m, p);
         t2 = fmul(x2, z1, m, p);
         s  = fmul(t1 ^ t2, t1 ^ t2, m, p);
         q  = fmul(t1, t2, m, p) ^ fmul(x, s, m, p);
         if (k[i]) begin
            x1 = q; z1 = s;
            t1 = fmul(x2, x2, m, p); t2 = fmul(z2, z2, m, p);
            z2 = fmul(t1, t2, m, p);
            x2 = fmul(t1, t1, m, p) ^ fmul(b, fmul(t2, t2, m, p), m, p);
         end else begin
            x2 = q; z2 = s;
            t1 = fmul(x1, x1, m, p); t2 = fmul(z1, z1, m, p);
            z1 = fmul(t1, t2, m, p);
            x1 = fmul(t1, t1, m, p) ^ fmul(b, fmul(t2, t2, m, p), m, p);
         end
      end
      ox1 = x1; oz1 = z1; ox2 = x2; oz2 = z2;
   endtask

   // ---------------- one run with per-cycle done comparison ----------------
   task automatic run(input bit big, input logic [162:0] x, input logic [162:0] b,
                      input logic [31:0] k, input bit mid_start);
      int m, kw, lat;
      logic [162:0] p, ex1, ez1, ex2, ez2, h1, h2, h3, h4;
      m   = big ? MB : MS;
      kw  = big ? KB : KS;
      p   = big ? PB : {156'd0, PS};
      lat = kw * (2 * m + 4);
      model(x & fmask(m), b & fmask(m), big ? k : {26'd0, k[5:0]}, m, kw, p,
            ex1, ez1, ex2, ez2);
      @(negedge clk);
      sel = big;
      xp = x; bb = b; kk = k;
      if (big) st_b = 1'b1; else st_s = 1'b1;
      @(negedge clk);
      st_b = 1'b0; st_s = 1'b0;
      for (int c = 0; c <= lat; c++) begin
         chk(rdone == (c == lat), "R6", "done timing", {162'd0, rdone}, {162'd0, (c == lat)});
         if (mid_start && c == 5) begin
            kk = ~k; xp = ~x;
            if (big) st_b = 1'b1; else st_s = 1'b1;
         end
         if (mid_start && c == 6) begin
            st_b = 1'b0; st_s = 1'b0; kk = k; xp = x;
         end
         if (c < lat) @(negedge clk);
      end
      chk(rx1 == ex1, mid_start ? "R8" : "R3", "x1", rx1, ex1);
      chk(rz1 == ez1, "R4", "z1", rz1, ez1);
      chk(rx2 == ex2, "R5", "x2", rx2, ex2);
      chk(rz2 == ez2, "R2", "z2", rz2, ez2);
      h1 = rx1; h2 = rz1; h3 = rx2; h4 = rz2;
      for (int c = 0; c < 3; c++) begin
         @(negedge clk);
         chk(rdone == 1'b0, "R7", "done pulse width", {162'd0, rdone}, '0);
         chk(rx1 == h1 && rz1 == h2 && rx2 == h3 && rz2 == h4, "R7", "hold x1",
             rx1, h1);
      end
      if (k == 32'd0 || (!big && k[5:0] == 6'd0)) begin
         chk(rz1 == '0, "R9", "k=0 z1", rz1, '0);
         chk(rx1 == 163'd1, "R9", "k=0 x1", rx1, 163'd1);
      end
      if (k == 32'd1) begin
         chk(rx1 == (x & fmask(m)), "R9", "k=1 x1", rx1, x & fmask(m));
         chk(rz1 == 163'd1, "R9", "k=1 z1", rz1, 163'd1);
         chk(rz2 == fmul(x, x, m, p), "R9", "k=1 z2", rz2, fmul(x, x, m, p));
         chk(rx2 == (fmul(fmul(x, x, m, p), fmul(x, x, m, p), m, p) ^ (b & fmask(m))),
             "R9", "k=1 x2", rx2,
             fmul(fmul(x, x, m, p), fmul(x, x, m, p), m, p) ^ (b & fmask(m)));
      end
   endtask

   function automatic logic [162:0] rnd163();
      return {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
   endfunction

   initial begin
      #2_000_000;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      rst_n = 1'b0; st_b = 1'b0; st_s = 1'b0;
      xp = '0; bb = '0; kk = '0; sel = 1'b0;
      repeat (3) @(negedge clk);
      // R1 under reset, both instances
      chk(b_x1 == '0 && b_z1 == '0 && b_x2 == '0 && b_z2 == '0, "R1", "big outputs", b_x1, '0);
      chk({s_x1, s_z1, s_x2, s_z2} == '0, "R1", "small outputs", {135'd0, s_x1, s_z1, s_x2, s_z2}, '0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(b_done == 1'b0 && s_done == 1'b0, "R1", "done after reset", {161'd0, b_done, s_done}, '0);

      // small field: several scalar patterns
      run(1'b0, 163'h35, 163'h01, 32'h00, 1'b0);  // R9 zero scalar
      run(1'b0, 163'h35, 163'h01, 32'h01, 1'b0);  // R9 / R2 leading zeros
      run(1'b0, 163'h52, 163'h0B, 32'h2D, 1'b0);  // R3 R4 mixed bits
      run(1'b0, 163'h6A, 163'h01, 32'h3F, 1'b0);  // R3 all ones
      run(1'b0, 163'h19, 163'h44, 32'h20, 1'b0);  // R4 lone top bit
      run(1'b0, 163'h27, 163'h13, 32'h15, 1'b1);  // R8 start while busy

      // full-size field
      run(1'b1, rnd163(), rnd163(), 32'd1, 1'b0);      // R9 / R5
      run(1'b1, rnd163(), 163'd1, 32'd0, 1'b0);        // R9
      run(1'b1, rnd163(), rnd163(), $urandom, 1'b0);   // R3 R4 R5
      run(1'b1, rnd163(), 163'd1, $urandom | 32'h8000_0000, 1'b1); // R8

      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule